// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This controller collects interrupt requests from a fixed, ordered set of sources and hands them one at a time to a processor core. Each request is held in a pending latch until it is either dispatched or cleared by software. A permanent mask decides which pending requests may be chosen. Among the eligible requests, the lowest index always has the highest priority.

An in-service register records every priority level whose service routine is currently running, one bit per source. When nesting is turned off, no new interrupt is issued while any of these bits is set. When nesting is turned on, a request may preempt only if its index is strictly lower than the lowest set in-service bit. A return strobe from the core ends the innermost routine by clearing the lowest set in-service bit. Nested routines therefore retire in last-in, first-out order. Requests that arrive during service are not lost; they are issued in priority order once the routines that block them have finished.

A small state machine drives the core interface. In ST_IDLE it evaluates eligibility. The transition GRANT moves it to ST_OFFER with the chosen vector registered. In ST_OFFER it holds `irq_valid` and the vector steady. An acknowledge from the core (ACCEPT) dispatches the interrupt and returns to ST_IDLE. If the offered request stops being eligible before it is acknowledged (WITHDRAW), the machine also returns to ST_IDLE, and nothing is dispatched.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, `irq_valid` is 0, `pending` is all zeros and `in_service` is all zeros.
- R2: A 1 on `irq_req[i]` at a clock edge makes `pending[i]` 1 after that edge. The bit stays set until the request is dispatched or cleared. A pending bit whose `perm_mask` bit is 0 is never offered, but it stays pending.
- R3: When `irq_req[i]` and `sw_clr[i]` are both 1 at the same edge, `pending[i]` is 1 afterwards. When only `sw_clr[i]` is 1, `pending[i]` is 0 afterwards.
- R4: The offered vector is the lowest index i with `pending[i] & perm_mask[i]`. `irq_valid` rises two edges after the request edge. While `irq_valid` is high and no acknowledge has been taken, `irq_vector` does not change, even if a higher-priority request arrives.
- R5: When `irq_ack` is 1 while `irq_valid` is 1, the edge sets `in_service[irq_vector]`, clears `pending[irq_vector]` (unless it is requested again in that cycle), and drops `irq_valid`.
- R6: When `nest_en` is 0, no offer begins while any `in_service` bit is set.
- R7: When `nest_en` is 1 and `in_service` is non-zero, an offer begins only for an index strictly lower than the lowest set `in_service` index.
- R8: A 1 on `irq_rfi` clears the lowest-index set bit of `in_service`. It has no effect when `in_service` is zero.
- R9: When `irq_rfi` and an accepted acknowledge occur in the same cycle, the return clears the old lowest bit first, and then the accepted vector's bit is set.
- R10: If the offered request loses its pending bit or its `perm_mask` bit while no acknowledge is given, `irq_valid` falls and `in_service` is unchanged.
- R11: Requests latched while they are blocked are issued one by one, in ascending index order, once the blocking routines have returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | N | Request lines, bit 0 has the highest priority |
| sw_clr | input | N | Software clear of pending bits |
| perm_mask | input | N | Permanent enable mask, 1 = eligible |
| nest_en | input | 1 | 1 = nesting allowed, 0 = one routine at a time |
| irq_ack | input | 1 | Core accepts the offered vector |
| irq_rfi | input | 1 | Core returns from the innermost routine |
| irq_valid | output | 1 | An interrupt is offered |
| irq_vector | output | VW | Index of the offered source |
| pending | output | N | Latched requests |
| in_service | output | N | Temporary mask pointer, one bit per level in service |

## Verification
The assertions check on every cycle the rules that can be stated locally in time:
- requests always land in the pending latch;
- an accepted vector always appears in the in-service register;
- a return clears exactly the lowest set bit;
- an offer never starts against the nesting rule, whether nesting is on or off;
- the vector stays still while it is offered.

Only the bench scenarios can show the longer sequences:
- the full order in which many latched requests drain through the masks;
- a withdrawn offer leaving no trace;
- a request winning against a simultaneous clear;
- the sweep over every pair of in-service level and new request, with nesting on and with nesting off.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1
    } nirq_state_t;
endpackage

// File: rtl/nirq_pend_latch.sv
module nirq_pend_latch #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] take,
    output logic [N-1:0] pend
);
    logic [N-1:0] pend_q;

    // A fresh request always wins over any clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr & ~take) | req;
    end

    assign pend = pend_q;
endmodule

// File: rtl/nirq_prio_pick.sv
module nirq_prio_pick #(
    parameter int N  = 8,
    parameter int VW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  bits,
    output logic          any,
    output logic [VW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits[i]) idx = VW'(i);
        end
    end

    assign any = |bits;
endmodule

// File: rtl/nirq_inserv_stack.sv
module nirq_inserv_stack #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pop,
    input  logic [N-1:0] push,
    output logic [N-1:0] ptr
);
    logic [N-1:0] ptr_q;
    logic [N-1:0] popped;

    // Clearing the lowest set bit removes the innermost nesting level.
    assign popped = pop ? (ptr_q & (ptr_q - {{(N-1){1'b0}}, 1'b1})) : ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= popped | push;
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/nirq_seq_fsm.sv
module nirq_seq_fsm
    import nirq_pkg::*;
#(
    parameter int N  = 8,
    parameter int VW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  elig,
    input  logic          cand_any,
    input  logic [VW-1:0] cand_idx,
    input  logic          busy,
    input  logic [VW-1:0] top_idx,
    input  logic          nest_en,
    input  logic          irq_ack,
    output logic          irq_valid,
    output logic [VW-1:0] irq_vector,
    output logic [N-1:0]  take
);
    nirq_state_t state_q, state_d;
    logic [VW-1:0] vec_q;
    logic          grant;
    logic          still_ok;

    assign grant    = cand_any && (!busy || (nest_en && (cand_idx < top_idx)));
    assign still_ok = elig[vec_q];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (grant) state_d = ST_OFFER;
            ST_OFFER: if (irq_ack || !still_ok) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            vec_q <= '0;
        else if (state_q == ST_IDLE && grant)  vec_q <= cand_idx;
    end

    always_comb begin
        irq_valid  = (state_q == ST_OFFER);
        irq_vector = vec_q;
        take       = '0;
        if (state_q == ST_OFFER && irq_ack) take = {{(N-1){1'b0}}, 1'b1} << vec_q;
    end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
    parameter int N  = 8,
    parameter int VW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_req,
    input  logic [N-1:0]  sw_clr,
    input  logic [N-1:0]  perm_mask,
    input  logic          nest_en,
    input  logic          irq_ack,
    input  logic          irq_rfi,
    output logic          irq_valid,
    output logic [VW-1:0] irq_vector,
    output logic [N-1:0]  pending,
    output logic [N-1:0]  in_service
);
    logic [N-1:0]  take;
    logic [N-1:0]  elig;
    logic          cand_any;
    logic [VW-1:0] cand_idx;
    logic          busy;
    logic [VW-1:0] top_idx;

    assign elig = pending & perm_mask;

    nirq_pend_latch #(.N(N)) u_pend (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (irq_req),
        .clr  (sw_clr),
        .take (take),
        .pend (pending)
    );

    nirq_prio_pick #(.N(N), .VW(VW)) u_pick_cand (
        .bits(elig),
        .any (cand_any),
        .idx (cand_idx)
    );

    nirq_prio_pick #(.N(N), .VW(VW)) u_pick_top (
        .bits(in_service),
        .any (busy),
        .idx (top_idx)
    );

    nirq_inserv_stack #(.N(N)) u_stack (
        .clk  (clk),
        .rst_n(rst_n),
        .pop  (irq_rfi),
        .push (take),
        .ptr  (in_service)
    );

    nirq_seq_fsm #(.N(N), .VW(VW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .elig      (elig),
        .cand_any  (cand_any),
        .cand_idx  (cand_idx),
        .busy      (busy),
        .top_idx   (top_idx),
        .nest_en   (nest_en),
        .irq_ack   (irq_ack),
        .irq_valid (irq_valid),
        .irq_vector(irq_vector),
        .take      (take)
    );
endmodule

// File: rtl/nest_irq_ctrl_chk.sv
module nest_irq_ctrl_chk #(
    parameter int N  = 8,
    parameter int VW = (N > 1) ? $clog2(N) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  irq_req,
    input logic          nest_en,
    input logic          irq_ack,
    input logic          irq_rfi,
    input logic          irq_valid,
    input logic [VW-1:0] irq_vector,
    input logic [N-1:0]  pending,
    input logic [N-1:0]  in_service
);
    logic          ins_any;
    logic [VW-1:0] ins_low;
    logic [N-1:0]  ins_popped;

    always_comb begin
        ins_low = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (in_service[i]) ins_low = VW'(i);
        end
    end

    assign ins_any    = |in_service;
    assign ins_popped = in_service & (in_service - {{(N-1){1'b0}}, 1'b1});

    AST_REQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pending & $past(irq_req)) == $past(irq_req))); // R2

    AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && $past(irq_valid) && !$past(irq_ack)) |-> $stable(irq_vector)); // R4

    AST_ACK_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_ack) |=> in_service[$past(irq_vector)]); // R5

    AST_NO_NEST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_valid) && !$past(nest_en)) |-> !$past(ins_any)); // R6

    AST_PREEMPT_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_valid) && $past(ins_any)) |-> (irq_vector < $past(ins_low))); // R7

    AST_RFI_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rfi && !(irq_valid && irq_ack)) |=> (in_service == $past(ins_popped))); // R8

    AST_RFI_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rfi && irq_valid && irq_ack) |=>
        (in_service == ($past(ins_popped) | ({{(N-1){1'b0}}, 1'b1} << $past(irq_vector))))); // R9
endmodule

bind nest_irq_ctrl nest_irq_ctrl_chk #(.N(N), .VW(VW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .nest_en   (nest_en),
    .irq_ack   (irq_ack),
    .irq_rfi   (irq_rfi),
    .irq_valid (irq_valid),
    .irq_vector(irq_vector),
    .pending   (pending),
    .in_service(in_service)
);

// File: tb/tb_nest_irq_ctrl.sv
`timescale 1ns/1ps
module tb_nest_irq_ctrl;
    localparam int N  = 8;
    localparam int VW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_req = '0;
    logic [N-1:0]  sw_clr = '0;
    logic [N-1:0]  perm_mask = '1;
    logic          nest_en = 1'b0;
    logic          irq_ack = 1'b0;
    logic          irq_rfi = 1'b0;
    logic          irq_valid;
    logic [VW-1:0] irq_vector;
    logic [N-1:0]  pending;
    logic [N-1:0]  in_service;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    nest_irq_ctrl #(.N(N), .VW(VW)) dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .sw_clr(sw_clr),
        .perm_mask(perm_mask), .nest_en(nest_en), .irq_ack(irq_ack),
        .irq_rfi(irq_rfi), .irq_valid(irq_valid), .irq_vector(irq_vector),
        .pending(pending), .in_service(in_service)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        irq_req = '0; sw_clr = '0; irq_ack = 1'b0; irq_rfi = 1'b0;
        rst_n = 1'b0;
        step(1);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic pulse_req(input logic [N-1:0] p);
        irq_req = p; step(1); irq_req = '0;
    endtask

    task automatic accept();
        irq_ack = 1'b1; step(1); irq_ack = 1'b0;
    endtask

    task automatic rfi();
        irq_rfi = 1'b1; step(1); irq_rfi = 1'b0;
    endtask

    task automatic wait_valid();
        for (int k = 0; k < 6; k++) begin
            if (irq_valid) break;
            step(1);
        end
    endtask

    function automatic int lowest(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    initial begin
        #400000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1 valid", int'(irq_valid), 0);
        chk("R1 pending", int'(pending), 0);
        chk("R1 in_service", int'(in_service), 0);

        // R4 timing: offer two edges after the request edge
        pulse_req(8'h10);
        chk("R2 latched", int'(pending), 8'h10);
        chk("R4 not yet valid", int'(irq_valid), 0);
        step(1);
        chk("R4 valid", int'(irq_valid), 1);
        chk("R4 vector", int'(irq_vector), 4);

        // R6 and R7 sweep over in-service level s and new request r
        for (int nest = 0; nest < 2; nest++) begin
            for (int s = 0; s < N; s++) begin
                for (int r = 0; r < N; r++) begin
                    do_reset();
                    nest_en = nest[0];
                    perm_mask = '1;
                    pulse_req(8'(1) << s);
                    wait_valid();
                    chk("R4 first vector", int'(irq_vector), s);
                    accept();
                    chk("R5 in_service set", int'(in_service), 1 << s);
                    chk("R5 pending cleared", int'(pending), 0);
                    pulse_req(8'(1) << r);
                    step(3);
                    if (nest == 1 && r < s) begin
                        chk("R7 preempt", int'(irq_valid), 1);
                        chk("R7 vector", int'(irq_vector), r);
                        accept();
                        chk("R7 nested mask", int'(in_service), (1 << s) | (1 << r));
                        rfi();
                        chk("R8 pop inner", int'(in_service), 1 << s);
                        rfi();
                        chk("R8 pop outer", int'(in_service), 0);
                    end else begin
                        chk(nest == 1 ? "R7 blocked" : "R6 blocked", int'(irq_valid), 0);
                        chk("R2 kept pending", int'(pending[r]), 1);
                        rfi();
                        chk("R8 pop", int'(in_service), 0);
                        wait_valid();
                        chk("R11 later dispatch", int'(irq_vector), r);
                        chk("R11 later valid", int'(irq_valid), 1);
                    end
                end
            end
        end

        // R11 and R2: every request pattern drains in ascending order through the mask
        nest_en = 1'b0;
        for (int p = 1; p < 256; p++) begin
            logic [N-1:0] m;
            logic [N-1:0] e;
            do_reset();
            m = p[0] ? 8'hFF : 8'h5A;
            perm_mask = m;
            pulse_req(p[N-1:0]);
            e = p[N-1:0] & m;
            while (e != 0) begin
                wait_valid();
                chk("R11 order", int'(irq_vector), lowest(e));
                accept();
                chk("R5 single level", int'(in_service), 1 << lowest(e));
                rfi();
                e = e & (e - 8'd1);
            end
            step(4);
            chk("R2 masked idle", int'(irq_valid), 0);
            chk("R2 masked kept", int'(pending), int'(p[N-1:0] & ~m));
        end

        // R3 request versus clear
        do_reset();
        perm_mask = '0;
        pulse_req(8'h08);
        irq_req = 8'h08; sw_clr = 8'h08; step(1); irq_req = '0; sw_clr = '0;
        chk("R3 request wins", int'(pending), 8'h08);
        irq_req = 8'h04; sw_clr = 8'h08; step(1); irq_req = '0; sw_clr = '0;
        chk("R3 clear alone", int'(pending), 8'h04);
        step(3);
        chk("R2 masked never offered", int'(irq_valid), 0);

        // R10 withdraw by clear and by mask
        do_reset();
        perm_mask = '1;
        pulse_req(8'h40);
        wait_valid();
        sw_clr = 8'h40; step(1); sw_clr = '0;
        step(2);
        chk("R10 clear withdraw", int'(irq_valid), 0);
        chk("R10 no dispatch", int'(in_service), 0);
        pulse_req(8'h20);
        wait_valid();
        perm_mask = 8'hDF; step(3);
        chk("R10 mask withdraw", int'(irq_valid), 0);
        chk("R10 still pending", int'(pending), 8'h20);
        perm_mask = '1;

        // R4 vector held while a higher request arrives
        do_reset();
        nest_en = 1'b0;
        pulse_req(8'h40);
        wait_valid();
        pulse_req(8'h02);
        step(2);
        chk("R4 held vector", int'(irq_vector), 6);
        accept();
        step(3);
        chk("R6 blocked after accept", int'(irq_valid), 0);
        rfi();
        wait_valid();
        chk("R11 next vector", int'(irq_vector), 1);

        // R9 return and accept in the same cycle
        do_reset();
        nest_en = 1'b1;
        pulse_req(8'h20);
        wait_valid();
        accept();
        pulse_req(8'h04);
        wait_valid();
        chk("R7 offer 2", int'(irq_vector), 2);
        irq_ack = 1'b1; irq_rfi = 1'b1; step(1); irq_ack = 1'b0; irq_rfi = 1'b0;
        chk("R9 pop then push", int'(in_service), 8'h04);
        rfi();
        rfi();
        chk("R8 empty no effect", int'(in_service), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule